// File: doc/BRIEF.md
# Shifter with Condition Flags

This combinational unit performs the three shift operations of a compact 16-bit instruction set that works on 32-bit data: logical left, logical right and arithmetic right. The shift count comes either from a 5-bit immediate field or from the least significant byte of a register value. The unit returns the shifted word together with the next values of the negative, zero and carry flags. It also returns a strobe that tells the caller whether carry was written or only carried through from the current value.

The surrounding datapath supplies the operand, the shift kind, the count source, the immediate, the register value and the present carry. It commits the results itself. The unit has no state, no register file and no decoder. The rules for a zero immediate depend on the shift kind. Register counts of zero, exactly the data width, and more than the data width each have their own result and carry rules.

Top module: `shf_unit`

## Requirements
- R1: With kind_i = 0 (logical left), use_reg_i = 0 and imm_i = 0, result_o equals opnd_i, carry_o equals carry_i and carry_wr_o is 0.
- R2: For a logical left shift by an immediate n from 1 to 31, result_o = opnd_i << n and carry_o = opnd_i[32-n].
- R3: With use_reg_i = 0 and imm_i = 0, the right shifts (kind_i = 1 logical, kind_i = 2 arithmetic) shift by 32. Logical right gives result_o = 0. Arithmetic right gives all bits equal to opnd_i[31]. In both cases carry_o = opnd_i[31].
- R4: For a right shift by an immediate n from 1 to 31, logical right fills with zeros, arithmetic right fills with opnd_i[31], and carry_o = opnd_i[n-1].
- R5: With use_reg_i = 1, only rval_i[7:0] sets the count and rval_i[31:8] has no effect. A count of 0 gives result_o = opnd_i, carry_o = carry_i and carry_wr_o = 0.
- R6: A register count from 1 to 31 follows the same result and carry rules as an immediate count of that value, for all three kinds.
- R7: A register logical right shift by exactly 32 gives result_o = 0 and carry_o = opnd_i[31]. A count above 32 gives result_o = 0 and carry_o = 0.
- R8: A register arithmetic right shift by 32 or more gives carry_o = opnd_i[31] and sets every bit of result_o to opnd_i[31].
- R9: A register logical left shift by exactly 32 gives result_o = 0 and carry_o = opnd_i[0]. A count above 32 gives result_o = 0 and carry_o = 0.
- R10: For every operation, neg_o equals result_o[31] and zero_o is 1 exactly when result_o is zero.
- R11: carry_wr_o is 1 exactly when the effective count is non-zero and the kind is 0, 1 or 2. Whenever carry_wr_o is 0, carry_o equals carry_i.
- R12: kind_i = 3 is reserved. It gives result_o = opnd_i, carry_o = carry_i and carry_wr_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift kind: 0 logical left, 1 logical right, 2 arithmetic right, 3 reserved |
| use_reg_i | input | 1 | 1 takes the count from rval_i, 0 takes it from imm_i |
| imm_i | input | 5 | Immediate shift count |
| rval_i | input | 32 | Register value; its low byte is the count |
| carry_i | input | 1 | Present carry flag |
| result_o | output | 32 | Shifted word |
| neg_o | output | 1 | Next negative flag |
| zero_o | output | 1 | Next zero flag |
| carry_o | output | 1 | Next carry flag |
| carry_wr_o | output | 1 | 1 when carry_o is a newly computed value |

## Verification
Every output is a combinational function of the present inputs, so each result is due in the same cycle as its stimulus, with no register on the path. The bench changes the inputs just after a rising edge and compares all five outputs at the following falling edge, half a period later, when the logic has settled. The sweep covers every kind and every immediate count. It also covers all 256 register counts, with junk in the upper register bits, for several operands and both carry-in values, so the 0, 32 and 33 boundaries are all reached.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        SK_LSL = 2'd0,
        SK_LSR = 2'd1,
        SK_ASR = 2'd2,
        SK_RSV = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic carry_wr;
    } shf_flags_t;

    function automatic logic kind_is_right(shift_kind_e k);
        return (k == SK_LSR) || (k == SK_ASR);
    endfunction

    function automatic logic kind_is_valid(shift_kind_e k);
        return k != SK_RSV;
    endfunction

endpackage

// File: rtl/shf_amount.sv
module shf_amount
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8,
    parameter int SW        = $clog2(DATA_W + 2)
) (
    input  shift_kind_e          kind_i,
    input  logic                 use_reg_i,
    input  logic [IMM_W-1:0]     imm_i,
    input  logic [REG_AMT_W-1:0] reg_amt_i,
    output logic [SW-1:0]        amt_o,
    output logic                 shift_on_o
);
    // Counts beyond DATA_W+1 behave exactly like DATA_W+1.
    localparam logic [REG_AMT_W-1:0] LIMIT    = REG_AMT_W'(DATA_W + 1);
    localparam logic [REG_AMT_W-1:0] FULL_CNT = REG_AMT_W'(DATA_W);

    logic [REG_AMT_W-1:0] raw;

    always_comb begin
        if (use_reg_i) begin
            raw = reg_amt_i;
        end else if (imm_i == '0 && kind_is_right(kind_i)) begin
            raw = FULL_CNT;
        end else begin
            raw = REG_AMT_W'(imm_i);
        end
        shift_on_o = (raw != '0) && kind_is_valid(kind_i);
        amt_o      = (raw > LIMIT) ? LIMIT[SW-1:0] : raw[SW-1:0];
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int W  = 64,
    parameter int SW = 6
) (
    input  logic [W-1:0]  vec_i,
    input  logic          left_i,
    input  logic          fill_i,
    input  logic [SW-1:0] amt_i,
    output logic [W-1:0]  vec_o
);
    logic [W-1:0] stage [SW+1];

    assign stage[0] = vec_i;

    for (genvar g = 0; g < SW; g++) begin : g_stage
        localparam int D = 2 ** g;
        logic [W-1:0] shl, shr;
        assign shl = {stage[g][W-1-D:0], {D{1'b0}}};
        assign shr = {{D{fill_i}}, stage[g][W-1:D]};
        assign stage[g+1] = amt_i[g] ? (left_i ? shl : shr) : stage[g];
    end

    assign vec_o = stage[SW];

endmodule

// File: rtl/shf_flags.sv
module shf_flags
    import shf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              shift_carry_i,
    input  logic              shift_on_i,
    input  logic              carry_i,
    output shf_flags_t        flags_o
);
    always_comb begin
        flags_o.neg      = result_i[DATA_W-1];
        flags_o.zero     = (result_i == '0);
        flags_o.carry    = shift_on_i ? shift_carry_i : carry_i;
        flags_o.carry_wr = shift_on_i;
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8
) (
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [1:0]        kind_i,
    input  logic              use_reg_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic [DATA_W-1:0] rval_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] result_o,
    output logic              neg_o,
    output logic              zero_o,
    output logic              carry_o,
    output logic              carry_wr_o
);
    localparam int SW  = $clog2(DATA_W + 2);
    localparam int EXT = 2 * DATA_W;

    shift_kind_e     kind;
    logic [SW-1:0]   amt;
    logic            shift_on;
    logic            left;
    logic            fill;
    logic [EXT-1:0]  ext_in, ext_out;
    logic [DATA_W-1:0] shifted;
    logic            shift_carry;
    shf_flags_t      flags;

    assign kind = shift_kind_e'(kind_i);

    shf_amount #(
        .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AMT_W(REG_AMT_W), .SW(SW)
    ) u_amt (
        .kind_i     (kind),
        .use_reg_i  (use_reg_i),
        .imm_i      (imm_i),
        .reg_amt_i  (rval_i[REG_AMT_W-1:0]),
        .amt_o      (amt),
        .shift_on_o (shift_on)
    );

    // The operand sits in one half of a double-width word. The half it
    // leaves last carries the bit shifted out last into the carry slot.
    assign left   = (kind == SK_LSL);
    assign fill   = (kind == SK_ASR) && opnd_i[DATA_W-1];
    assign ext_in = left ? {{DATA_W{1'b0}}, opnd_i} : {opnd_i, {DATA_W{1'b0}}};

    shf_barrel #(.W(EXT), .SW(SW)) u_bar (
        .vec_i  (ext_in),
        .left_i (left),
        .fill_i (fill),
        .amt_i  (amt),
        .vec_o  (ext_out)
    );

    always_comb begin
        if (left) begin
            shifted     = ext_out[DATA_W-1:0];
            shift_carry = ext_out[DATA_W];
        end else begin
            shifted     = ext_out[EXT-1:DATA_W];
            shift_carry = ext_out[DATA_W-1];
        end
        result_o = shift_on ? shifted : opnd_i;
    end

    shf_flags #(.DATA_W(DATA_W)) u_flg (
        .result_i      (result_o),
        .shift_carry_i (shift_carry),
        .shift_on_i    (shift_on),
        .carry_i       (carry_i),
        .flags_o       (flags)
    );

    assign neg_o      = flags.neg;
    assign zero_o     = flags.zero;
    assign carry_o    = flags.carry;
    assign carry_wr_o = flags.carry_wr;

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int DATA_W    = 32,
    parameter int IMM_W     = 5,
    parameter int REG_AMT_W = 8
) (
    input logic [DATA_W-1:0] opnd_i,
    input logic [1:0]        kind_i,
    input logic              use_reg_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] rval_i,
    input logic              carry_i,
    input logic [DATA_W-1:0] result_o,
    input logic              neg_o,
    input logic              zero_o,
    input logic              carry_o,
    input logic              carry_wr_o
);
    logic [REG_AMT_W-1:0] ramt;
    logic                 known;

    assign ramt  = rval_i[REG_AMT_W-1:0];
    assign known = !$isunknown({opnd_i, kind_i, use_reg_i, imm_i, rval_i, carry_i});

    always_comb begin
        if (known) begin
            p_hold_r11: assert (carry_wr_o || carry_o == carry_i)
                else $error("carry changed without write strobe");
            p_zero_cnt_r5: assert (!(use_reg_i && ramt == '0) || (result_o == opnd_i && !carry_wr_o))
                else $error("zero register count altered state");
            p_lsl_big_r9: assert (!(use_reg_i && kind_i == 2'd0 && int'(ramt) > DATA_W)
                                  || (result_o == '0 && !carry_o))
                else $error("left shift past width wrong");
            p_asr_fill_r8: assert (!(use_reg_i && kind_i == 2'd2 && int'(ramt) >= DATA_W)
                                   || (result_o == {DATA_W{opnd_i[DATA_W-1]}} && carry_o == opnd_i[DATA_W-1]))
                else $error("arithmetic fill wrong");
            p_lsr_imm0_r3: assert (!(!use_reg_i && kind_i == 2'd1 && imm_i == '0)
                                   || (result_o == '0 && carry_o == opnd_i[DATA_W-1]))
                else $error("zero immediate right shift wrong");
            p_reserved_r12: assert (kind_i != 2'd3 || (result_o == opnd_i && !carry_wr_o))
                else $error("reserved kind altered state");
        end
    end

endmodule

bind shf_unit shf_unit_chk #(
    .DATA_W(DATA_W), .IMM_W(IMM_W), .REG_AMT_W(REG_AMT_W)
) u_chk (
    .opnd_i     (opnd_i),
    .kind_i     (kind_i),
    .use_reg_i  (use_reg_i),
    .imm_i      (imm_i),
    .rval_i     (rval_i),
    .carry_i    (carry_i),
    .result_o   (result_o),
    .neg_o      (neg_o),
    .zero_o     (zero_o),
    .carry_o    (carry_o),
    .carry_wr_o (carry_wr_o)
);

// File: tb/sim_shf_unit.sv
`timescale 1ns/1ps
module sim_shf_unit;

    logic        clk = 1'b0;
    logic [31:0] opnd_i;
    logic [1:0]  kind_i;
    logic        use_reg_i;
    logic [4:0]  imm_i;
    logic [31:0] rval_i;
    logic        carry_i;
    logic [31:0] result_o;
    logic        neg_o, zero_o, carry_o, carry_wr_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    shf_unit u0 (
        .opnd_i     (opnd_i),
        .kind_i     (kind_i),
        .use_reg_i  (use_reg_i),
        .imm_i      (imm_i),
        .rval_i     (rval_i),
        .carry_i    (carry_i),
        .result_o   (result_o),
        .neg_o      (neg_o),
        .zero_o     (zero_o),
        .carry_o    (carry_o),
        .carry_wr_o (carry_wr_o)
    );

    // Expected behaviour, worked case by case from the requirements.
    task automatic model(input logic [31:0] op, input logic [1:0] k, input logic ureg,
                         input logic [4:0] imm, input logic [31:0] rv, input logic cin,
                         output logic [31:0] res, output logic c, output logic wr,
                         output string tag);
        int n;
        n = ureg ? int'(rv[7:0]) : int'(imm);
        if (k == 2'd3) begin
            res = op; c = cin; wr = 0; tag = "R12"; return;
        end
        if (!ureg && n == 0 && k != 2'd0) begin
            n = 32;
        end
        if (n == 0) begin
            res = op; c = cin; wr = 0;
            tag = ureg ? "R5" : "R1";
            return;
        end
        wr  = 1;
        tag = ureg ? "R6" : (k == 2'd0 ? "R2" : "R4");
        if (n < 32) begin
            case (k)
                2'd0: begin res = op << n;                    c = op[32-n]; end
                2'd1: begin res = op >> n;                    c = op[n-1];  end
                default: begin res = 32'($signed(op) >>> n);  c = op[n-1];  end
            endcase
        end else begin
            if (!ureg) tag = "R3";
            else if (k == 2'd0) tag = "R9";
            else if (k == 2'd1) tag = "R7";
            else tag = "R8";
            case (k)
                2'd0: begin res = '0; c = (n == 32) ? op[0]  : 1'b0; end
                2'd1: begin res = '0; c = (n == 32) ? op[31] : 1'b0; end
                default: begin res = {32{op[31]}}; c = op[31]; end
            endcase
        end
    endtask

    task automatic apply_check(input logic [31:0] op, input logic [1:0] k, input logic ureg,
                               input logic [4:0] imm, input logic [31:0] rv, input logic cin);
        logic [31:0] er;
        logic ec, ew;
        string tag;
        @(posedge clk);
        opnd_i = op; kind_i = k; use_reg_i = ureg; imm_i = imm; rval_i = rv; carry_i = cin;
        model(op, k, ureg, imm, rv, cin, er, ec, ew, tag);
        @(negedge clk);
        checks++;
        if (result_o !== er || carry_o !== ec || carry_wr_o !== ew) begin
            errors++;
            $display("FAIL %s op=%h k=%0d reg=%0d imm=%0d rv=%h cin=%0d: res=%h c=%0d wr=%0d exp res=%h c=%0d wr=%0d",
                     tag, op, k, ureg, imm, rv, cin, result_o, carry_o, carry_wr_o, er, ec, ew);
        end
        checks++;
        if (neg_o !== er[31] || zero_o !== (er == 0)) begin
            errors++;
            $display("FAIL R10 op=%h k=%0d n=%0d z=%0d exp n=%0d z=%0d",
                     op, k, neg_o, zero_o, er[31], er == 0);
        end
    endtask

    logic [31:0] ops [6];

    initial begin
        ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE; ops[2] = 32'hDEAD_BEEF;
        ops[3] = 32'h0000_0000; ops[4] = 32'hFFFF_FFFF; ops[5] = 32'h1234_5678;
        opnd_i = 32'h0; kind_i = 2'd0; use_reg_i = 1'b0; imm_i = 5'd0; rval_i = 32'h0; carry_i = 1'b1;
        // Initial state: zero count left shift of zero (R1, R10)
        @(negedge clk);
        checks++;
        if (result_o !== 32'h0 || carry_o !== 1'b1 || carry_wr_o !== 1'b0 || zero_o !== 1'b1) begin
            errors++;
            $display("FAIL R1 initial: res=%h c=%0d wr=%0d z=%0d exp 0 1 0 1",
                     result_o, carry_o, carry_wr_o, zero_o);
        end
        // Immediate sweep: R1 R2 R3 R4 R12
        for (int k = 0; k < 4; k++)
            for (int i = 0; i < 32; i++)
                for (int o = 0; o < 6; o++)
                    for (int c = 0; c < 2; c++)
                        apply_check(ops[o], 2'(k), 1'b0, 5'(i), 32'hFFFF_FF00 ^ 32'(o), 1'(c));
        // Register sweep with junk upper bits: R5 R6 R7 R8 R9 R11
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
                for (int o = 0; o < 6; o++)
                    for (int c = 0; c < 2; c++)
                        apply_check(ops[o], 2'(k), 1'b1, 5'(a ^ 7), {24'hA5_3C_96 ^ 24'(a * 77), 8'(a)}, 1'(c));
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int cyc = 0; cyc < 150000; cyc++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule